// File: doc/BRIEF.md
# Multiprecision Multiply-Accumulate Unit

This unit helps a 64-bit core run large-integer arithmetic. It keeps private state: three multiplier limbs that together form a 192-bit multiplier, and three partial-sum limbs that carry the upper part of a running product from one operation to the next. Software loads the multiplier once. It then issues a chain of multiply-accumulate operations, one source limb at a time. Each operation returns the next 64-bit limb of the long product and keeps the rest in the partial-sum limbs.

An operation is issued with a one-cycle `start` pulse, an operation code, a limb select (used by the load operations only) and two 64-bit source operands `rs` and `rt`. The unit answers with a one-cycle `done` pulse. The result is on `rd` in that cycle and stays there until the next result. A one-cycle `fault` pulse goes with `done` when the operation is refused. The unit has a single 64x64 multiplier and walks over the multiplier limbs with it, so the wide operation takes one cycle per limb. All six state limbs are visible on read ports.

Top module: `mpmac_unit`

## Requirements
- R1: After reset, all multiplier and partial-sum limbs, `rd`, `done` and `fault` are zero.
- R2: Operation code 0 (load multiplier) writes `rs` into the multiplier limb chosen by `limb_sel` and clears all three partial-sum limbs. `done` pulses one cycle after the start edge.
- R3: Operation code 1 (load partial) writes `rs` into the partial-sum limb chosen by `limb_sel` and leaves every other limb unchanged. `done` pulses one cycle after the start edge.
- R4: Operation code 2 (single multiply-accumulate) computes rs*mult0 + rt + part0 as a 128-bit value. `rd` gets bits 63:0 and part0 gets bits 127:64, which includes the carries of both additions. part1, part2 and all multiplier limbs are unchanged. `done` pulses two cycles after the start edge.
- R5: Operation code 3 (multiply and move) forms the same low 64 bits as R4. It writes them to `rd` and to mult0, and clears all three partial-sum limbs. `done` pulses two cycles after the start edge.
- R6: Operation code 4 (wide multiply-accumulate) computes rs * {mult2,mult1,mult0} + rt + {part2,part1,part0} as a 256-bit value. `rd` gets bits 63:0. part0, part1 and part2 get bits 127:64, 191:128 and 255:192. `done` pulses LIMBS+1 cycles after the start edge.
- R7: While `mul_disable` is high at the start edge, any operation gives `fault` and `done` together, one cycle later. No limb and no bit of `rd` changes.
- R8: An operation code of 5, 6 or 7, or a load whose `limb_sel` is 3 or more, is refused in the same way as in R7.
- R9: A `start` pulse that arrives while an operation is still in progress is ignored. It neither changes state nor produces a further `done`.
- R10: All products and sums are unsigned. All-ones operands and limbs give an all-ones 256-bit wide result with no lost carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that issues an operation while the unit is idle |
| op | input | 3 | Operation code (0 load multiplier, 1 load partial, 2 single MAC, 3 multiply and move, 4 wide MAC) |
| limb_sel | input | 2 | Limb index for the load operations |
| rs | input | 64 | First source operand |
| rt | input | 64 | Second source operand (addend) |
| mul_disable | input | 1 | When high, every operation is refused |
| rd | output | 64 | Destination result, held until the next result |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Reserved-instruction fault, pulses with `done` |
| mult_limbs | output | 192 | Multiplier limbs, limb i at bits 64*i+63:64*i |
| part_limbs | output | 192 | Partial-sum limbs, limb i at bits 64*i+63:64*i |

## Verification
A wrong partial-sum limb stays hidden in `rd` until a later multiply-accumulate folds it in. For that reason the bench compares all six limbs on the read ports after every operation, and a fault shows at the very next `done`. A carry lost between limbs shows as a single off-by-one limb. The all-ones wide case and random chains against a 256-bit bench reference are there to expose it. Wrong step counting shows as a `done` that comes early or late, or a stray `done`, and the bench measures the cycle count of every operation.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;
    typedef enum logic [2:0] {
        MP_LOAD_MUL  = 3'd0,
        MP_LOAD_PART = 3'd1,
        MP_MAC       = 3'd2,
        MP_MAC_MOVE  = 3'd3,
        MP_WIDE      = 3'd4
    } mp_op_e;
endpackage

// File: rtl/mpmac_mul.sv
module mpmac_mul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    // full-width unsigned product
    assign p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
endmodule

// File: rtl/mpmac_limb_mux.sv
module mpmac_limb_mux #(
    parameter int W     = 64,
    parameter int LIMBS = 3,
    parameter int SELW  = 2
) (
    input  logic [LIMBS-1:0][W-1:0] limbs,
    input  logic [SELW-1:0]         sel,
    output logic [W-1:0]            y
);
    logic [LIMBS-1:0][W-1:0] masked;

    for (genvar g = 0; g < LIMBS; g++) begin : g_mask
        assign masked[g] = (sel == SELW'(g)) ? limbs[g] : '0;
    end

    always_comb begin
        y = '0;
        for (int i = 0; i < LIMBS; i++) y = y | masked[i];
    end
endmodule

// File: rtl/mpmac_shift_add.sv
module mpmac_shift_add #(
    parameter int W     = 64,
    parameter int LIMBS = 3,
    parameter int SELW  = 2,
    parameter int ACCW  = W * (LIMBS + 1)
) (
    input  logic [ACCW-1:0]  acc,
    input  logic [2*W-1:0]   prod,
    input  logic [SELW-1:0]  pos,
    output logic [ACCW-1:0]  sum
);
    logic [LIMBS-1:0][ACCW-1:0] placed;
    logic [ACCW-1:0]            addend;

    // product aligned to the limb position being processed
    for (genvar g = 0; g < LIMBS; g++) begin : g_place
        assign placed[g] = (pos == SELW'(g)) ? (ACCW'(prod) << (g * W)) : '0;
    end

    always_comb begin
        addend = '0;
        for (int i = 0; i < LIMBS; i++) addend = addend | placed[i];
        sum = acc + addend;
    end
endmodule

// File: rtl/mpmac_unit.sv
module mpmac_unit
    import mpmac_pkg::*;
#(
    parameter int W     = 64,
    parameter int LIMBS = 3,
    localparam int SELW = (LIMBS > 1) ? $clog2(LIMBS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op,
    input  logic [SELW-1:0]    limb_sel,
    input  logic [W-1:0]       rs,
    input  logic [W-1:0]       rt,
    input  logic               mul_disable,
    output logic [W-1:0]       rd,
    output logic               done,
    output logic               fault,
    output logic [LIMBS*W-1:0] mult_limbs,
    output logic [LIMBS*W-1:0] part_limbs
);
    localparam int ACCW = W * (LIMBS + 1);

    typedef struct packed {
        logic [LIMBS-1:0][W-1:0] mult;
        logic [LIMBS-1:0][W-1:0] part;
        logic [ACCW-1:0]         acc;
        logic [SELW-1:0]         step;
        logic [SELW-1:0]         last;
        logic [2:0]              op;
        logic [W-1:0]            src;
        logic                    busy;
        logic                    done;
        logic                    fault;
        logic [W-1:0]            rd;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0]    limb_now;
    logic [2*W-1:0]  prod;
    logic [ACCW-1:0] acc_sum;
    logic            legal;

    mpmac_limb_mux #(.W(W), .LIMBS(LIMBS), .SELW(SELW)) u_mux (
        .limbs (st_q.mult),
        .sel   (st_q.step),
        .y     (limb_now)
    );

    mpmac_mul #(.W(W)) u_mul (
        .a (st_q.src),
        .b (limb_now),
        .p (prod)
    );

    mpmac_shift_add #(.W(W), .LIMBS(LIMBS), .SELW(SELW), .ACCW(ACCW)) u_add (
        .acc  (st_q.acc),
        .prod (prod),
        .pos  (st_q.step),
        .sum  (acc_sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        legal      = 1'b0;
        case (mp_op_e'(op))
            MP_LOAD_MUL, MP_LOAD_PART: legal = (int'(limb_sel) < LIMBS);
            MP_MAC, MP_MAC_MOVE, MP_WIDE: legal = 1'b1;
            default: legal = 1'b0;
        endcase

        if (!st_q.busy) begin
            if (start) begin
                if (mul_disable || !legal) begin
                    st_d.fault = 1'b1;
                    st_d.done  = 1'b1;
                end else begin
                    case (mp_op_e'(op))
                        MP_LOAD_MUL: begin
                            st_d.mult[limb_sel] = rs;
                            st_d.part           = '0;
                            st_d.done           = 1'b1;
                        end
                        MP_LOAD_PART: begin
                            st_d.part[limb_sel] = rs;
                            st_d.done           = 1'b1;
                        end
                        MP_WIDE: begin
                            st_d.busy = 1'b1;
                            st_d.step = '0;
                            st_d.last = SELW'(LIMBS - 1);
                            st_d.acc  = ACCW'(rt) + ACCW'(st_q.part);
                            st_d.src  = rs;
                            st_d.op   = op;
                        end
                        default: begin
                            st_d.busy = 1'b1;
                            st_d.step = '0;
                            st_d.last = '0;
                            st_d.acc  = ACCW'(rt) + ACCW'(st_q.part[0]);
                            st_d.src  = rs;
                            st_d.op   = op;
                        end
                    endcase
                end
            end
        end else begin
            st_d.acc  = acc_sum;
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.rd   = acc_sum[W-1:0];
                case (mp_op_e'(st_q.op))
                    MP_MAC:      st_d.part[0] = acc_sum[2*W-1:W];
                    MP_MAC_MOVE: begin
                        st_d.mult[0] = acc_sum[W-1:0];
                        st_d.part    = '0;
                    end
                    default:     st_d.part = acc_sum[ACCW-1:W];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd         = st_q.rd;
    assign done       = st_q.done;
    assign fault      = st_q.fault;
    assign mult_limbs = st_q.mult;
    assign part_limbs = st_q.part;

    // R7: a refused operation always completes
    a_r7_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |-> st_q.done);

    // R7 / R8: a refused operation leaves every limb and rd untouched
    a_r7_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |-> ($stable(st_q.mult) && $stable(st_q.part) && $stable(st_q.rd)));

    // R2: a multiplier load issued from idle leaves the partial sum cleared
    a_r2_load_clears_part: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_q.busy) && (st_q.mult != $past(st_q.mult))) |-> (st_q.part == '0));

    // R9: completion is never reported while a step is still pending
    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    // R4: a single-limb MAC touches no partial limb above limb 0
    a_r4_upper_parts_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !st_q.fault && $past(st_q.busy) && (st_q.op == MP_MAC))
        |-> $stable(st_q.part[LIMBS-1:1]));
endmodule

// File: tb/mpmac_unit_bench.sv
`timescale 1ns/1ps
module mpmac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  limb_sel = '0;
    logic [63:0] rs = '0, rt = '0;
    logic        mul_disable = 1'b0;
    logic [63:0] rd;
    logic        done, fault;
    logic [191:0] mult_limbs, part_limbs;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_mul [3];
    logic [63:0] m_part [3];
    logic [63:0] m_rd;

    always #2 clk = ~clk;

    mpmac_unit u_mpmac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .limb_sel(limb_sel),
        .rs(rs), .rt(rt), .mul_disable(mul_disable), .rd(rd), .done(done),
        .fault(fault), .mult_limbs(mult_limbs), .part_limbs(part_limbs)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        for (int i = 0; i < 3; i++) begin
            chk(req, $sformatf("mult limb %0d", i), 256'(mult_limbs[64*i +: 64]), 256'(m_mul[i]));
            chk(req, $sformatf("part limb %0d", i), 256'(part_limbs[64*i +: 64]), 256'(m_part[i]));
        end
        chk(req, "rd", 256'(rd), 256'(m_rd));
    endtask

    // reference model: updates the bench state to the expected outcome
    task automatic predict(input logic [2:0] o, input logic [1:0] s,
                           input logic [63:0] a, input logic [63:0] b, input logic dis,
                           output int lat, output logic f);
        logic [127:0] t;
        logic [255:0] w;
        logic         legal;
        legal = (o <= 3'd4) && !((o <= 3'd1) && (s >= 2'd3));
        f   = 1'b0;
        lat = 1;
        if (dis || !legal) begin
            f = 1'b1;
        end else begin
            case (o)
                3'd0: begin
                    m_mul[s] = a;
                    for (int i = 0; i < 3; i++) m_part[i] = '0;
                end
                3'd1: m_part[s] = a;
                3'd2, 3'd3: begin
                    t = 128'(a) * 128'(m_mul[0]) + 128'(b) + 128'(m_part[0]);
                    m_rd = t[63:0];
                    lat = 2;
                    if (o == 3'd2) m_part[0] = t[127:64];
                    else begin
                        m_mul[0] = t[63:0];
                        for (int i = 0; i < 3; i++) m_part[i] = '0;
                    end
                end
                default: begin
                    w = 256'(a) * {64'd0, m_mul[2], m_mul[1], m_mul[0]}
                        + 256'(b) + {64'd0, m_part[2], m_part[1], m_part[0]};
                    m_rd = w[63:0];
                    m_part[0] = w[127:64];
                    m_part[1] = w[191:128];
                    m_part[2] = w[255:192];
                    lat = 4;
                end
            endcase
        end
    endtask

    function automatic string req_of(input logic [2:0] o, input logic [1:0] s,
                                     input logic dis);
        if (dis) return "R7";
        if (o > 3'd4 || (o <= 3'd1 && s == 2'd3)) return "R8";
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [1:0] s,
                          input logic [63:0] a, input logic [63:0] b, input logic dis,
                          input string req);
        int   e_lat, lat;
        logic e_f;
        predict(o, s, a, b, dis, e_lat, e_f);
        @(negedge clk);
        start = 1'b1; op = o; limb_sel = s; rs = a; rt = b; mul_disable = dis;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 16);
        chk(req, "latency", 256'(lat), 256'(e_lat));
        chk(req, "fault", 256'(fault), 256'(e_f));
        check_state(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int   e_lat, lat, stray;
        logic e_f;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin m_mul[i] = '0; m_part[i] = '0; end
        m_rd = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "done", 256'(done), 256'(0));
        chk("R1", "fault", 256'(fault), 256'(0));
        check_state("R1");

        // directed: load chain and a simple single MAC
        run_op(3'd0, 2'd0, 64'd7, 64'd0, 1'b0, "R2");
        run_op(3'd1, 2'd2, 64'h55, 64'd0, 1'b0, "R3");
        run_op(3'd1, 2'd0, 64'd9, 64'd0, 1'b0, "R3");
        run_op(3'd2, 2'd0, 64'd3, 64'd5, 1'b0, "R4");
        run_op(3'd0, 2'd1, 64'd1, 64'd0, 1'b0, "R2");
        // R10 all-ones wide case
        for (int i = 0; i < 3; i++) run_op(3'd0, 2'(i), '1, '0, 1'b0, "R10");
        for (int i = 0; i < 3; i++) run_op(3'd1, 2'(i), '1, '0, 1'b0, "R10");
        run_op(3'd4, 2'd0, '1, '1, 1'b0, "R10");
        // R4 carries with all-ones operands
        run_op(3'd1, 2'd0, '1, '0, 1'b0, "R4");
        run_op(3'd2, 2'd0, '1, '1, 1'b0, "R4");
        run_op(3'd3, 2'd0, 64'hdead_beef, 64'h1234, 1'b0, "R5");
        // R7 / R8 refusals
        run_op(3'd4, 2'd0, '1, '1, 1'b1, "R7");
        run_op(3'd0, 2'd3, 64'd44, 64'd0, 1'b0, "R8");
        run_op(3'd6, 2'd0, 64'd44, 64'd0, 1'b0, "R8");

        // R9: start while busy is ignored
        predict(3'd4, 2'd0, 64'h0123_4567_89ab_cdef, 64'd77, 1'b0, e_lat, e_f);
        @(negedge clk);
        start = 1'b1; op = 3'd4; limb_sel = 2'd0; rs = 64'h0123_4567_89ab_cdef; rt = 64'd77;
        mul_disable = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            start = (lat == 0);
            op = 3'd0; rs = 64'hffff_0000_ffff_0000;
            lat++;
        end while (!done && lat < 16);
        start = 1'b0;
        chk("R9", "latency", 256'(lat), 256'(e_lat));
        check_state("R9");
        stray = 0;
        repeat (4) begin @(negedge clk); if (done) stray++; end
        chk("R9", "extra done", 256'(stray), 256'(0));

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  o;
            logic [1:0]  s;
            logic [63:0] a, b;
            logic        dis;
            int          pick;
            pick = int'($urandom_range(0, 19));
            if      (pick < 3)  o = 3'd0;
            else if (pick < 6)  o = 3'd1;
            else if (pick < 10) o = 3'd2;
            else if (pick < 12) o = 3'd3;
            else if (pick < 18) o = 3'd4;
            else                o = 3'($urandom_range(5, 7));
            s   = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            a   = {$urandom, $urandom};
            b   = {$urandom, $urandom};
            dis = ($urandom_range(0, 15) == 0);
            run_op(o, s, a, b, dis, req_of(o, s, dis));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule